// File: doc/BRIEF.md
# Command/Indication Channel Register

This block is the host-facing side of the command/indication exchange of a layer-1 line controller. Through a byte-wide register port the host writes a 4-bit command code. The block holds that code and drives it toward the line side until the next valid command arrives.

In the other direction the line side presents a primary and a secondary 4-bit indication code, and a strobe marks each frame. A new code is accepted only when two consecutive frames carry the same value, so single-frame glitches never reach the host. An accepted code is latched together with a change flag. A shared interrupt status bit is raised, and an interrupt output follows it through a mask byte. Reading the primary receive register returns the code and the flags, and clears the pending change.

Register addresses are fixed: 0 is interrupt status (read), 1 is the mask (read/write), 2 is the primary receive register on read and the command register on write, and 3 is the secondary receive register (read).

Top module: `ci_channel`

## Requirements
- R1: After reset, `cmd_out` is 0 and `irq` is low. Address 0 reads 0x00, address 1 reads 0xFF, and addresses 2 and 3 both read 0x3C (code 0xF in bits 5:2, no flags).
- R2: A write to address 2 whose bits 1:0 are both one loads bits 5:2 of the byte onto `cmd_out` from the next clock edge.
- R3: A write to address 2 whose bits 1:0 are not both one leaves `cmd_out` unchanged.
- R4: A new indication code is latched only on the second of two consecutive `frame_tick` cycles that carry that same code. Cycles without `frame_tick` neither count nor break the pair.
- R5: A code present on only one frame, followed by a return to the latched code, causes no latch, no flag and no status bit.
- R6: Address 2 reads {2'b00, primary code, change flag, secondary-new flag}, with the code in bits 5:2, the change flag in bit 1 and the secondary-new flag in bit 0.
- R7: Latching a new secondary code sets bit 0 of address 2. Address 3 reads {2'b00, secondary code, 2'b00}, and reading address 3 clears that bit 0.
- R8: Latching a new code on either channel sets interrupt status bit 2 (value 0x04 at address 0). All other status bits read 0.
- R9: Reading address 2 clears bit 1, bit 0 and status bit 2 at the end of that read cycle. The byte returned is the state before the clear.
- R10: `irq` is high exactly when status bit 2 is set and mask bit 2 is clear. A mask of 0xFF blocks it and 0x00 passes it. The mask reads back at address 1.
- R11: When a latch and a clearing read of address 2 fall in the same cycle, the flags and the status bit end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear-on-read side effects) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from current state |
| frame_tick | input | 1 | One-cycle strobe per line-side frame |
| ind_primary | input | 4 | Primary indication code from the line side |
| ind_secondary | input | 4 | Secondary indication code from the line side |
| cmd_out | output | 4 | Command code toward the line side |
| irq | output | 1 | Masked C/I change interrupt |

## Verification
A wrong filter state, such as a stale previous-frame sample, shows up at address 2 one frame early or one frame late. It can also appear as a spurious change flag right after a glitch frame. A flag or status bit that fails to clear, or clears over a simultaneous latch, is visible in the very next read of address 0 or 2 and on `irq` in the following cycle. A corrupted command register shows on `cmd_out` one edge after the write.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int CODE_W   = 4;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int N_CHAN   = 2;
  localparam int STAT_BIT = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_STAT = 2'd0,
    ADR_MASK = 2'd1,
    ADR_PRIM = 2'd2,
    ADR_SEC  = 2'd3
  } ci_addr_e;

  function automatic logic [BYTE_W-1:0] pack_rx(input logic [CODE_W-1:0] code,
                                                 input logic hi_flag,
                                                 input logic lo_flag);
    return {2'b00, code, hi_flag, lo_flag};
  endfunction

  function automatic logic cmd_byte_valid(input logic [BYTE_W-1:0] b);
    return b[1:0] == 2'b11;
  endfunction

  function automatic logic [CODE_W-1:0] cmd_field(input logic [BYTE_W-1:0] b);
    return b[CODE_W+1:2];
  endfunction
endpackage

// File: rtl/ci_filter.sv
module ci_filter #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_CODE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_tick,
  input  logic [W-1:0] line_in,
  output logic [W-1:0] code_q,
  output logic         new_evt
);
  logic [W-1:0] prev_q;
  logic [W-1:0] code_r;

  assign new_evt = frame_tick && (line_in == prev_q) && (line_in != code_r);
  assign code_q  = code_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= RST_CODE;
      code_r <= RST_CODE;
    end else begin
      if (frame_tick) prev_q <= line_in;
      if (new_evt)    code_r <= line_in;
    end
  end

  assert_latch_on_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_r) |-> $past(frame_tick));

  assert_single_sighting_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && line_in != prev_q) |=> $stable(code_r));
endmodule

// File: rtl/ci_cmd_reg.sv
module ci_cmd_reg
  import ci_pkg::*;
#(
  parameter int W = CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [W-1:0]      cmd_q
);
  logic accept;
  assign accept = wr_en && cmd_byte_valid(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_q <= '0;
    else if (accept) cmd_q <= cmd_field(wdata);
  end

  assert_cmd_only_on_valid_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_q) |-> $past(wr_en) && $past(wdata[1:0]) == 2'b11);

  assert_cmd_takes_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[1:0] == 2'b11) |=> cmd_q == $past(wdata[5:2]));
endmodule

// File: rtl/ci_channel.sv
module ci_channel
  import ci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              frame_tick,
  input  logic [CODE_W-1:0] ind_primary,
  input  logic [CODE_W-1:0] ind_secondary,
  output logic [CODE_W-1:0] cmd_out,
  output logic              irq
);
  logic [N_CHAN-1:0][CODE_W-1:0] ind_bus;
  logic [N_CHAN-1:0][CODE_W-1:0] code_bus;
  logic [N_CHAN-1:0]             evt_bus;

  assign ind_bus[0] = ind_primary;
  assign ind_bus[1] = ind_secondary;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    ci_filter #(.W(CODE_W), .RST_CODE('1)) u_filt (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .line_in(ind_bus[c]), .code_q(code_bus[c]), .new_evt(evt_bus[c])
    );
  end

  logic rd_prim, rd_sec, wr_cmd, wr_mask, any_evt;
  assign rd_prim = reg_rd && reg_addr == ADR_PRIM;
  assign rd_sec  = reg_rd && reg_addr == ADR_SEC;
  assign wr_cmd  = reg_wr && reg_addr == ADR_PRIM;
  assign wr_mask = reg_wr && reg_addr == ADR_MASK;
  assign any_evt = |evt_bus;

  ci_cmd_reg #(.W(CODE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmd), .wdata(reg_wdata), .cmd_q(cmd_out)
  );

  logic              chg_q, sec_q, stat_q;
  logic [BYTE_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_q  <= 1'b0;
      sec_q  <= 1'b0;
      stat_q <= 1'b0;
      mask_q <= '1;
    end else begin
      if (evt_bus[0])         chg_q  <= 1'b1;
      else if (rd_prim)       chg_q  <= 1'b0;
      if (evt_bus[1])         sec_q  <= 1'b1;
      else if (rd_prim || rd_sec) sec_q <= 1'b0;
      if (any_evt)            stat_q <= 1'b1;
      else if (rd_prim)       stat_q <= 1'b0;
      if (wr_mask)            mask_q <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADR_STAT: reg_rdata = BYTE_W'(stat_q) << STAT_BIT;
      ADR_MASK: reg_rdata = mask_q;
      ADR_PRIM: reg_rdata = pack_rx(code_bus[0], chg_q, sec_q);
      default:  reg_rdata = pack_rx(code_bus[1], 1'b0, 1'b0);
    endcase
  end

  assign irq = stat_q && !mask_q[STAT_BIT];

  assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[STAT_BIT] |-> !irq);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_prim && !any_evt) |=> !stat_q && !chg_q && !sec_q);

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> stat_q);

  assert_flag_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_q) |-> $past(evt_bus[0]));
endmodule

// File: tb/test_ci_channel.sv
`timescale 1ns/1ps
module test_ci_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       frame_tick = 1'b0;
  logic [3:0] ind_primary = 4'hF, ind_secondary = 4'hF;
  logic [3:0] cmd_out;
  logic       irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  byte unsigned q_exp[$];
  string        q_tag[$];

  always #2 clk = ~clk;

  ci_channel i_ci_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
    .ind_primary(ind_primary), .ind_secondary(ind_secondary),
    .cmd_out(cmd_out), .irq(irq)
  );

  // monitor: compare each read against the scoreboard
  always @(negedge clk) begin
    if (reg_rd) begin
      byte unsigned e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_vec++;
      if (reg_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: addr %0d read %02h expected %02h", t, reg_addr, reg_rdata, e);
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    q_exp.push_back(exp); q_tag.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic tick(input logic [3:0] p, input logic [3:0] s);
    @(posedge clk); #1;
    ind_primary = p; ind_secondary = s; frame_tick = 1'b1;
    @(posedge clk); #1;
    frame_tick = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 cmd_out", {4'h0, cmd_out}, 8'h00);
    check("R1 irq", {7'h0, irq}, 8'h00);
    rd(2'd0, 8'h00, "R1 status");
    rd(2'd1, 8'hFF, "R1 mask");
    rd(2'd2, 8'h3C, "R1 primary");
    rd(2'd3, 8'h3C, "R1 secondary");
    // R2 / R3 command register
    wr(2'd2, 8'h27);
    check("R2 cmd code 9", {4'h0, cmd_out}, 8'h09);
    wr(2'd2, 8'h1C);
    check("R3 low bits 00 ignored", {4'h0, cmd_out}, 8'h09);
    wr(2'd2, 8'h16);
    check("R3 low bits 10 ignored", {4'h0, cmd_out}, 8'h09);
    wr(2'd2, 8'h3F);
    check("R2 cmd code F", {4'h0, cmd_out}, 8'h0F);
    // R10 mask readback
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h00, "R10 mask readback");
    // R4 two-frame filter
    tick(4'h5, 4'hF);
    repeat (3) @(posedge clk);
    rd(2'd2, 8'h3C, "R4 one frame not latched");
    tick(4'h5, 4'hF);
    rd(2'd0, 8'h04, "R8 status set");
    check("R10 irq passes", {7'h0, irq}, 8'h01);
    rd(2'd2, 8'h16, "R6 primary format");
    rd(2'd2, 8'h14, "R9 change cleared");
    rd(2'd0, 8'h00, "R9 status cleared");
    check("R10 irq low", {7'h0, irq}, 8'h00);
    // R5 glitch
    tick(4'hA, 4'hF);
    tick(4'h5, 4'hF);
    tick(4'h5, 4'hF);
    rd(2'd0, 8'h00, "R5 glitch no status");
    rd(2'd2, 8'h14, "R5 glitch no latch");
    // R7 secondary
    tick(4'h5, 4'h3);
    tick(4'h5, 4'h3);
    rd(2'd0, 8'h04, "R8 secondary sets status");
    rd(2'd3, 8'h0C, "R7 secondary code");
    rd(2'd2, 8'h14, "R7 bit0 cleared by secondary read");
    rd(2'd0, 8'h00, "R9 status cleared");
    // R10 masked
    wr(2'd1, 8'hFF);
    tick(4'hC, 4'h3);
    tick(4'hC, 4'h3);
    rd(2'd0, 8'h04, "R10 status with mask");
    check("R10 irq blocked", {7'h0, irq}, 8'h00);
    wr(2'd1, 8'h00);
    check("R10 irq after unmask", {7'h0, irq}, 8'h01);
    rd(2'd2, 8'h32, "R6 code C");
    check("R9 irq cleared", {7'h0, irq}, 8'h00);
    // R11 latch and read in the same cycle
    tick(4'h6, 4'h3);
    @(posedge clk); #1;
    ind_primary = 4'h6; frame_tick = 1'b1;
    q_exp.push_back(8'h30); q_tag.push_back("R11 read returns old state");
    reg_rd = 1'b1; reg_addr = 2'd2;
    @(posedge clk); #1;
    reg_rd = 1'b0; frame_tick = 1'b0;
    rd(2'd0, 8'h04, "R11 status survives");
    rd(2'd2, 8'h1A, "R11 flag survives");
    check("R11 cmd unchanged", {4'h0, cmd_out}, 8'h0F);
    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule